// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit

This block is the arithmetic core of a small accumulator-based controller. Each operation reads the accumulator, a second source byte, the B register byte and the incoming carry, auxiliary-carry and overflow flags. It returns a new accumulator, a new B register and new flags. The parity of the accumulator is always available as a flag of its own. The surrounding core reads its operands from the register file and writes the results back. Instruction decode and memory access stay outside this block.

Most operations complete on the clock edge that accepts them. Unsigned multiply and divide run over several cycles on an iterative datapath. While they run, `busy` is high. When they finish, `done` pulses and the result appears, split across the accumulator and B. A request that arrives while `busy` is high is dropped.

Top module: `acc_alu`

## Requirements
- R1: With op 0 (add) or op 1 (add plus carry), a_out is (a_in + src_in [+ cy_in]) mod 256. cy_out is the carry out of bit 7, ac_out is the carry out of bit 3, and ov_out flags a signed overflow. For example, 63H + 23H with carry clear gives 86H, cy 0, ov 1, parity 1.
- R2: Op 2 always computes a_in − src_in − cy_in. There is no form without borrow. cy_out and ac_out are the borrows out of bit 7 and bit 3, and ov_out flags a signed overflow.
- R3: Op 3 (increment) and op 4 (decrement) wrap modulo 256. They leave all three flags equal to their inputs.
- R4: Op 8 (AND), op 9 (OR) and op 10 (XOR) combine a_in with src_in bit by bit and pass the flags through unchanged. Every operation other than multiply and divide returns b_out equal to b_in.
- R5: Op 11 rotates A left and op 12 rotates A right. Op 13 and op 14 rotate left and right through the 9-bit ring formed by carry and A. Op 15 swaps the nibbles of A. For example, rotating right through carry with A=00H and C=1 gives 80H with C=0.
- R6: Op 5 is the decimal adjust. It adds 06H when the low nibble exceeds 9 or ac_in is set. It then adds 60H when the high nibble exceeds 9, a carry arose, or cy_in is set. cy_out is set on a decimal overflow. For example, 5AH adjusts to 60H.
- R7: Op 6 multiplies a_in by b_in. The low product byte goes to a_out and the high byte to b_out. ov_out = product > FFH and cy_out = 0. For example, 55H × 22H gives A=4AH, B=0BH, ov 1.
- R8: Op 7 divides a_in by b_in. The quotient goes to a_out and the remainder to b_out, with cy_out and ov_out both 0. When the divisor is zero, ov_out is 1 and cy_out is 0, and A and B are undefined.
- R9: A single-cycle operation updates the outputs and raises done for one cycle after the edge that accepts it. Multiply and divide hold busy for MD_CYCLES cycles. done rises as busy falls, and the outputs hold steady at all other times.
- R10: start is ignored while busy is high.
- R11: par_out is 1 exactly when a_out holds an odd number of ones.
- R12: After reset, all data outputs, flags, busy and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Operation request |
| op | input | 4 | Operation code |
| a_in | input | 8 | Accumulator operand |
| src_in | input | 8 | Second operand byte |
| b_in | input | 8 | B register operand |
| cy_in | input | 1 | Incoming carry |
| ac_in | input | 1 | Incoming auxiliary carry |
| ov_in | input | 1 | Incoming overflow |
| a_out | output | 8 | New accumulator |
| b_out | output | 8 | New B register |
| cy_out | output | 1 | Carry flag |
| ac_out | output | 1 | Auxiliary carry flag |
| ov_out | output | 1 | Overflow flag |
| par_out | output | 1 | Parity of a_out |
| busy | output | 1 | Multi-cycle operation in progress |
| done | output | 1 | Result updated on the last edge |

## Verification
The hardest case to reach is a new request that lands inside a multiply or divide window. The request must be dropped without corrupting the pending result. The divide-by-zero path must also be hit at the exact moment an iteration finishes. Directed sequences issue an add two cycles into a multiply, and a divide whose divisor is zero. A long random phase then asserts start on about two cycles in three, with random operands. This places requests on every phase of the iteration counter while the behavioural model tracks each cycle.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;

  typedef logic [DATA_W-1:0] byte_t;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADDC = 4'd1,  OP_SUBB = 4'd2,  OP_INC  = 4'd3,
    OP_DEC  = 4'd4,  OP_DA   = 4'd5,  OP_MUL  = 4'd6,  OP_DIV  = 4'd7,
    OP_AND  = 4'd8,  OP_OR   = 4'd9,  OP_XOR  = 4'd10, OP_RL   = 4'd11,
    OP_RR   = 4'd12, OP_RLC  = 4'd13, OP_RRC  = 4'd14, OP_SWAP = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } alu_flags_t;

  typedef struct packed {
    byte_t      val;
    alu_flags_t fl;
  } alu_res_t;

  // binary sum with carry-in; flags from bit 3 and bit 7
  function automatic alu_res_t add_bytes(byte_t a, byte_t s, logic cin);
    logic [NIB_W:0]  lo;
    logic [DATA_W:0] full;
    alu_res_t r;
    lo    = {1'b0, a[NIB_W-1:0]} + {1'b0, s[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
    full  = {1'b0, a} + {1'b0, s} + {{DATA_W{1'b0}}, cin};
    r.val = full[DATA_W-1:0];
    r.fl.cy = full[DATA_W];
    r.fl.ac = lo[NIB_W];
    r.fl.ov = (a[DATA_W-1] == s[DATA_W-1]) && (r.val[DATA_W-1] != a[DATA_W-1]);
    return r;
  endfunction

  // difference with borrow-in; top bit of the widened result is the borrow
  function automatic alu_res_t sub_bytes(byte_t a, byte_t s, logic bin);
    logic [NIB_W:0]  lo;
    logic [DATA_W:0] full;
    alu_res_t r;
    lo    = {1'b0, a[NIB_W-1:0]} - {1'b0, s[NIB_W-1:0]} - {{NIB_W{1'b0}}, bin};
    full  = {1'b0, a} - {1'b0, s} - {{DATA_W{1'b0}}, bin};
    r.val = full[DATA_W-1:0];
    r.fl.cy = full[DATA_W];
    r.fl.ac = lo[NIB_W];
    r.fl.ov = (a[DATA_W-1] != s[DATA_W-1]) && (r.val[DATA_W-1] != a[DATA_W-1]);
    return r;
  endfunction

  // packed BCD correction after an addition
  function automatic alu_res_t decimal_adjust(byte_t a, alu_flags_t fin);
    logic [DATA_W:0] t;
    alu_res_t r;
    t = {1'b0, a};
    if (a[NIB_W-1:0] > 4'd9 || fin.ac) t = t + 9'h006;
    if (t[DATA_W-1:NIB_W] > 4'd9 || t[DATA_W] || fin.cy) t = t + 9'h060;
    r.val   = t[DATA_W-1:0];
    r.fl.cy = fin.cy | t[DATA_W];
    r.fl.ac = fin.ac;
    r.fl.ov = fin.ov;
    return r;
  endfunction
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
  import acc_alu_pkg::*;
(
  input  alu_op_e    op,
  input  byte_t      a,
  input  byte_t      src,
  input  alu_flags_t fin,
  output alu_res_t   res,
  output logic       hit
);
  always_comb begin
    hit = 1'b1;
    res = '{val: a, fl: fin};
    unique case (op)
      OP_ADD:  res = add_bytes(a, src, 1'b0);
      OP_ADDC: res = add_bytes(a, src, fin.cy);
      OP_SUBB: res = sub_bytes(a, src, fin.cy);
      OP_INC:  res.val = a + byte_t'(1);
      OP_DEC:  res.val = a - byte_t'(1);
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
  import acc_alu_pkg::*;
(
  input  alu_op_e    op,
  input  byte_t      a,
  input  byte_t      src,
  input  alu_flags_t fin,
  output alu_res_t   res
);
  always_comb begin
    res = '{val: a, fl: fin};
    case (op)
      OP_AND:  res.val = a & src;
      OP_OR:   res.val = a | src;
      OP_XOR:  res.val = a ^ src;
      OP_RL:   res.val = {a[DATA_W-2:0], a[DATA_W-1]};
      OP_RR:   res.val = {a[0], a[DATA_W-1:1]};
      OP_RLC: begin
        res.val    = {a[DATA_W-2:0], fin.cy};
        res.fl.cy  = a[DATA_W-1];
      end
      OP_RRC: begin
        res.val    = {fin.cy, a[DATA_W-1:1]};
        res.fl.cy  = a[0];
      end
      OP_SWAP: res.val = {a[NIB_W-1:0], a[DATA_W-1:NIB_W]};
      OP_DA:   res = decimal_adjust(a, fin);
      default: res = '{val: a, fl: fin};
    endcase
  end
endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv #(
  parameter int W      = 8,
  parameter int CYCLES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic         is_div,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic         last_step,
  output logic         div_mode,
  output logic         div_zero,
  output logic [W-1:0] res_lo,
  output logic [W-1:0] res_hi
);
  localparam int STEPS = W / CYCLES;
  localparam int CW    = $clog2(CYCLES + 1);

  logic          busy_q, div_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  hi_q, lo_q, m_q;
  logic [W-1:0]  hi_n, lo_n;

  // STEPS iterations of shift-add (multiply) or restoring subtract (divide)
  always_comb begin
    logic [W:0]   h;
    logic [W-1:0] l;
    h = {1'b0, hi_q};
    l = lo_q;
    for (int i = 0; i < STEPS; i++) begin
      if (div_q) begin
        h = {h[W-1:0], l[W-1]};
        l = {l[W-2:0], 1'b0};
        if (h >= {1'b0, m_q}) begin
          h    = h - {1'b0, m_q};
          l[0] = 1'b1;
        end
      end else begin
        if (l[0]) h = h + {1'b0, m_q};
        l = {h[0], l[W-1:1]};
        h = {1'b0, h[W:1]};
      end
    end
    hi_n = h[W-1:0];
    lo_n = l;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      div_q  <= 1'b0;
      cnt_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      m_q    <= '0;
    end else if (busy_q) begin
      hi_q  <= hi_n;
      lo_q  <= lo_n;
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) busy_q <= 1'b0;
    end else if (go) begin
      busy_q <= 1'b1;
      div_q  <= is_div;
      cnt_q  <= CW'(CYCLES);
      hi_q   <= '0;
      lo_q   <= opa;
      m_q    <= opb;
    end
  end

  assign busy      = busy_q;
  assign last_step = busy_q && (cnt_q == CW'(1));
  assign div_mode  = div_q;
  assign div_zero  = div_q && (m_q == '0);
  assign res_lo    = lo_n;
  assign res_hi    = hi_n;
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int MD_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] op,
  input  logic [7:0] a_in,
  input  logic [7:0] src_in,
  input  logic [7:0] b_in,
  input  logic       cy_in,
  input  logic       ac_in,
  input  logic       ov_in,
  output logic [7:0] a_out,
  output logic [7:0] b_out,
  output logic       cy_out,
  output logic       ac_out,
  output logic       ov_out,
  output logic       par_out,
  output logic       busy,
  output logic       done
);
  alu_op_e    op_e;
  alu_flags_t fin;
  alu_res_t   as_res, bo_res, sel_res;
  logic       as_hit;

  logic       is_md, accept, single_go, md_go;
  logic       md_busy, md_last, md_div, md_dz, md_dz_fin;
  byte_t      md_lo, md_hi;

  byte_t      a_q, b_q;
  alu_flags_t fl_q;
  logic       done_q, md_ac_q;

  assign op_e      = alu_op_e'(op);
  assign fin       = '{cy: cy_in, ac: ac_in, ov: ov_in};
  assign is_md     = (op_e == OP_MUL) || (op_e == OP_DIV);
  assign accept    = start && !md_busy;
  assign single_go = accept && !is_md;
  assign md_go     = accept && is_md;
  assign md_dz_fin = md_last && md_div && md_dz;

  acc_alu_addsub u_addsub (
    .op(op_e), .a(a_in), .src(src_in), .fin(fin), .res(as_res), .hit(as_hit)
  );

  acc_alu_bitops u_bitops (
    .op(op_e), .a(a_in), .src(src_in), .fin(fin), .res(bo_res)
  );

  assign sel_res = as_hit ? as_res : bo_res;

  acc_alu_muldiv #(.W(DATA_W), .CYCLES(MD_CYCLES)) u_muldiv (
    .clk(clk), .rst_n(rst_n), .go(md_go), .is_div(op_e == OP_DIV),
    .opa(a_in), .opb(b_in), .busy(md_busy), .last_step(md_last),
    .div_mode(md_div), .div_zero(md_dz), .res_lo(md_lo), .res_hi(md_hi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q     <= '0;
      b_q     <= '0;
      fl_q    <= '0;
      done_q  <= 1'b0;
      md_ac_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (single_go) begin
        a_q    <= sel_res.val;
        b_q    <= b_in;
        fl_q   <= sel_res.fl;
        done_q <= 1'b1;
      end else if (md_last) begin
        a_q     <= md_lo;
        b_q     <= md_hi;
        fl_q.cy <= 1'b0;
        fl_q.ac <= md_ac_q;
        fl_q.ov <= md_div ? md_dz : (|md_hi);
        done_q  <= 1'b1;
      end
      if (md_go) md_ac_q <= ac_in;
    end
  end

  assign a_out   = a_q;
  assign b_out   = b_q;
  assign cy_out  = fl_q.cy;
  assign ac_out  = fl_q.ac;
  assign ov_out  = fl_q.ov;
  assign par_out = ^a_q;
  assign busy    = md_busy;
  assign done    = done_q;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int MD_CYCLES = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic [7:0] a_out,
  input logic [7:0] b_out,
  input logic       cy_out,
  input logic       ov_out,
  input logic       md_last,
  input logic       md_dz_fin
);
  int busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(a_out) && $stable(b_out)));

  assert_window_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && busy_len == MD_CYCLES));

  assert_no_done_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  assert_md_clears_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    md_last |=> (done && !cy_out));

  assert_div_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    md_dz_fin |=> (ov_out && !cy_out));
endmodule

bind acc_alu acc_alu_chk #(.MD_CYCLES(MD_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .a_out(a_out),
  .b_out(b_out), .cy_out(cy_out), .ov_out(ov_out), .md_last(md_last),
  .md_dz_fin(md_dz_fin)
);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  localparam int MDC = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] a_in = 8'd0, src_in = 8'd0, b_in = 8'd0;
  logic       cy_in = 1'b0, ac_in = 1'b0, ov_in = 1'b0;
  logic [7:0] a_out, b_out;
  logic       cy_out, ac_out, ov_out, par_out, busy, done;

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R12";
  bit    finished = 0;

  // behavioural model state
  logic [7:0] m_a = 0, m_b = 0, p_a = 0, p_b = 0;
  logic       m_cy = 0, m_ac = 0, m_ov = 0, p_cy = 0, p_ac = 0, p_ov = 0;
  logic       m_busy = 0, m_done = 0, m_skip = 0, p_skip = 0;
  int         m_cnt = 0;
  bit         model_live = 0;

  always #2 clk = ~clk;

  acc_alu #(.MD_CYCLES(MDC)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .a_in(a_in),
    .src_in(src_in), .b_in(b_in), .cy_in(cy_in), .ac_in(ac_in), .ov_in(ov_in),
    .a_out(a_out), .b_out(b_out), .cy_out(cy_out), .ac_out(ac_out),
    .ov_out(ov_out), .par_out(par_out), .busy(busy), .done(done)
  );

  function automatic int sgn(int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    int a, s, b, c, ac, ov, ra, rb, rc, rac, rov, sr, t;
    bit rskip;
    model_live = 1;
    if (!rst_n) begin
      m_a = 0; m_b = 0; m_cy = 0; m_ac = 0; m_ov = 0;
      m_busy = 0; m_done = 0; m_skip = 0; m_cnt = 0;
    end else if (m_busy) begin
      m_cnt--;
      m_done = 0;
      if (m_cnt == 0) begin
        m_busy = 0; m_done = 1;
        m_a = p_a; m_b = p_b; m_cy = p_cy; m_ac = p_ac; m_ov = p_ov; m_skip = p_skip;
      end
    end else if (start) begin
      a = int'(a_in); s = int'(src_in); b = int'(b_in);
      c = int'(cy_in); ac = int'(ac_in); ov = int'(ov_in);
      ra = a; rb = b; rc = c; rac = ac; rov = ov; rskip = 0;
      case (int'(op))
        0, 1: begin
          if (op == 4'd0) c = 0;
          ra = (a + s + c) % 256; rc = int'((a + s + c) > 255);
          rac = int'((a % 16 + s % 16 + c) > 15);
          sr = sgn(a) + sgn(s) + c; rov = int'(sr > 127 || sr < -128);
        end
        2: begin
          ra = (a - s - c + 512) % 256; rc = int'((a - s - c) < 0);
          rac = int'((a % 16 - s % 16 - c) < 0);
          sr = sgn(a) - sgn(s) - c; rov = int'(sr > 127 || sr < -128);
        end
        3: ra = (a + 1) % 256;
        4: ra = (a + 255) % 256;
        5: begin
          t = a;
          if (t % 16 > 9 || ac == 1) t = t + 6;
          if ((t / 16) % 16 > 9 || t > 255 || c == 1) t = t + 96;
          rc = int'(c == 1 || t > 255); ra = t % 256;
        end
        6: begin
          ra = (a * b) % 256; rb = (a * b) / 256; rc = 0; rov = int'(a * b > 255);
        end
        7: begin
          rc = 0;
          if (b == 0) begin rov = 1; rskip = 1; end
          else begin ra = a / b; rb = a % b; rov = 0; end
        end
        8:  ra = a & s;
        9:  ra = a | s;
        10: ra = a ^ s;
        11: ra = ((a * 2) % 256) + a / 128;
        12: ra = a / 2 + (a % 2) * 128;
        13: begin ra = (a * 2) % 256 + c; rc = a / 128; end
        14: begin ra = a / 2 + c * 128; rc = a % 2; end
        default: ra = (a % 16) * 16 + a / 16;
      endcase
      if (op == 4'd6 || op == 4'd7) begin
        m_busy = 1; m_cnt = MDC; m_done = 0;
        p_a = ra[7:0]; p_b = rb[7:0]; p_cy = rc[0]; p_ac = rac[0]; p_ov = rov[0];
        p_skip = rskip;
      end else begin
        m_done = 1;
        m_a = ra[7:0]; m_b = rb[7:0]; m_cy = rc[0]; m_ac = rac[0]; m_ov = rov[0];
        m_skip = 0;
      end
    end else begin
      m_done = 0;
    end
  end

  // compare against the model away from the active edge
  always @(negedge clk) begin
    if (model_live && !finished) begin
      if (!m_skip) begin
        chk(cur_req, "a_out", int'(a_out), int'(m_a));
        chk(cur_req, "b_out", int'(b_out), int'(m_b));
        chk("R11", "par_out", int'(par_out), $countones(m_a) % 2);
      end
      chk(cur_req, "cy_out", int'(cy_out), int'(m_cy));
      chk(cur_req, "ac_out", int'(ac_out), int'(m_ac));
      chk(cur_req, "ov_out", int'(ov_out), int'(m_ov));
      chk("R9", "busy", int'(busy), int'(m_busy));
      chk("R9", "done", int'(done), int'(m_done));
    end
  end

  // called at a falling edge; returns at the falling edge after completion
  task automatic run_op(input logic [3:0] o, input logic [7:0] a, input logic [7:0] s,
                        input logic [7:0] b, input logic c, input logic x, input logic v);
    op = o; a_in = a; src_in = s; b_in = b; cy_in = c; ac_in = x; ov_in = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (o == 4'd6 || o == 4'd7) repeat (MDC) @(negedge clk);
  endtask

  task automatic finish_sim();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R12";
    chk("R12", "reset a_out", int'(a_out), 0);
    chk("R12", "reset busy/done", int'({busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    cur_req = "R1";
    run_op(4'd0, 8'h63, 8'h23, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R1", "add value", int'(a_out), 'h86);
    chk("R1", "add flags cy/ov/par", int'({cy_out, ov_out, par_out}), 3'b011);
    run_op(4'd1, 8'hF0, 8'h0F, 8'h00, 1'b1, 1'b0, 1'b0);
    chk("R1", "addc wrap", int'({cy_out, a_out}), 'h100);

    cur_req = "R2";
    run_op(4'd2, 8'h10, 8'h01, 8'h00, 1'b1, 1'b0, 1'b0);
    chk("R2", "subb value", int'(a_out), 'h0E);
    chk("R2", "subb half borrow", int'({cy_out, ac_out}), 2'b01);
    run_op(4'd2, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
    chk("R2", "subb borrow in only", int'({cy_out, a_out}), 'h1FF);

    cur_req = "R3";
    run_op(4'd3, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0);
    chk("R3", "inc wrap flags kept", int'({cy_out, ac_out, a_out}), 'h300);
    run_op(4'd4, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1);
    chk("R3", "dec wrap", int'({ov_out, a_out}), 'h1FF);

    cur_req = "R4";
    run_op(4'd8, 8'h35, 8'h53, 8'h9C, 1'b0, 1'b0, 1'b0);
    chk("R4", "and value and b passthrough", int'({a_out, b_out}), 'h119C);
    run_op(4'd10, 8'hFF, 8'h0F, 8'h00, 1'b1, 1'b0, 1'b1);
    chk("R4", "xor flags kept", int'({cy_out, ov_out, a_out}), 'h3F0);

    cur_req = "R5";
    run_op(4'd14, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
    chk("R5", "rrc ring", int'({cy_out, a_out}), 'h080);
    run_op(4'd15, 8'h3C, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R5", "swap", int'(a_out), 'hC3);
    run_op(4'd11, 8'h81, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R5", "rotate left", int'(a_out), 'h03);

    cur_req = "R6";
    run_op(4'd5, 8'h5A, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R6", "adjust 5A", int'({cy_out, a_out}), 'h060);
    run_op(4'd5, 8'h9A, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R6", "adjust decimal overflow", int'({cy_out, a_out}), 'h100);

    cur_req = "R7";
    run_op(4'd6, 8'h55, 8'h00, 8'h22, 1'b1, 1'b0, 1'b0);
    chk("R7", "mul product", int'({b_out, a_out}), 'h0B4A);
    chk("R7", "mul flags", int'({cy_out, ov_out}), 2'b01);

    cur_req = "R8";
    run_op(4'd7, 8'h64, 8'h00, 8'h07, 1'b1, 1'b0, 1'b1);
    chk("R8", "div quotient/remainder", int'({a_out, b_out}), 'h0E02);
    chk("R8", "div flags", int'({cy_out, ov_out}), 0);
    run_op(4'd7, 8'h64, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
    chk("R8", "div by zero flags", int'({cy_out, ov_out}), 1);

    // multi-cycle window timing and a start issued inside it
    cur_req = "R10";
    op = 4'd6; a_in = 8'h0F; b_in = 8'h11; cy_in = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9", "busy after accept", int'({busy, done}), 2'b10);
    @(negedge clk);
    op = 4'd0; a_in = 8'h01; src_in = 8'h01; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10", "start during busy ignored", int'({busy, done}), 2'b10);
    @(negedge clk);
    @(negedge clk);
    chk("R9", "done as busy falls", int'({busy, done}), 2'b01);
    chk("R10", "mul result survives", int'({b_out, a_out}), 'h00FF);
    @(negedge clk);
    chk("R10", "no extra done", int'(done), 0);

    cur_req = "R11";
    run_op(4'd9, 8'h01, 8'h06, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R11", "parity odd", int'(par_out), 1);
    run_op(4'd9, 8'h03, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R11", "parity even", int'(par_out), 0);

    // random traffic, including requests on every phase of a busy window
    cur_req = "R10";
    for (int i = 0; i < 4000; i++) begin
      op = 4'($urandom); a_in = 8'($urandom); src_in = 8'($urandom);
      b_in = 8'($urandom); cy_in = 1'($urandom); ac_in = 1'($urandom);
      ov_in = 1'($urandom);
      start = ($urandom % 3) != 0;
      @(negedge clk);
    end
    start = 1'b0;
    repeat (MDC + 2) @(negedge clk);
    finish_sim();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end
endmodule